// File: doc/BRIEF.md
# Instruction Image Packer

This block streams one program segment from a byte source into one of two byte-wide memories. A segment is announced by a start pulse together with a small descriptor: a word address, the number of bytes present in the stream, the number of bytes the segment must occupy in memory, and a flag that marks the segment as executable. The low bits of the word address are turned into a byte offset, and every byte the block writes goes to consecutive byte addresses from that offset.

An executable segment holds 24-bit instructions packed back to back. The packer widens them to 32-bit words by writing one zero byte after every group of three source bytes. It goes to the instruction memory and writes no extra fill. Any other segment goes to the data memory: its source bytes are copied unchanged and then zero bytes are written until the memory size is reached. A descriptor whose stream length is larger than its memory size is refused with a one-cycle error pulse and causes no write at all.

The byte source uses a valid/ready handshake. The memory port offers one byte per cycle and may stall. A registered write stage holds a stalled byte unchanged until it is taken. A one-cycle completion pulse follows the last accepted write of a segment.

Top module: `seg_image_packer`

## Requirements
- R1: A segment with `seg_exec`=1 is written with `wr_sel`=1 (instruction memory); a segment with `seg_exec`=0 is written with `wr_sel`=0 (data memory).
- R2: For an executable segment, source bytes are written in order and a 0x00 byte follows every third source byte; a trailing group of one or two bytes gets no padding byte.
- R3: The first write of a segment goes to byte address `{seg_paddr[19:0], 2'b00}`; upper address bits are ignored, and each later write of the segment goes to the previous address plus one.
- R4: For a data segment, the `seg_file_size` source bytes are written unchanged and then 0x00 bytes are written until exactly `seg_mem_size` bytes have been written.
- R5: An executable segment produces exactly `seg_file_size + floor(seg_file_size/3)` writes, whatever its `seg_mem_size`.
- R6: A source byte is taken only in a cycle with `in_valid` and `in_ready` both high, each taken byte is written once; while `wr_en` is high and `wr_stall` is high, `wr_en`, `wr_sel`, `wr_addr` and `wr_data` hold their values into the next cycle.
- R7: `done` is high for exactly one cycle per accepted segment, in the cycle after the edge at which its last write is taken, with no write pending; no write follows it.
- R8: When `seg_file_size` > `seg_mem_size` at a start, `seg_err` pulses for one cycle, no byte is taken from the stream, no write is made and `done` stays low.
- R9: After reset, `busy`, `in_ready`, `wr_en` and `done` are low; a start pulse while `busy` is high is ignored.
- R10: An executable segment with zero file size, or a data segment with zero file and memory size, ends with a `done` pulse and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_start | input | 1 | Start pulse; descriptor sampled with it |
| seg_paddr | input | 32 | Segment word address (low 20 bits used) |
| seg_file_size | input | 16 | Bytes supplied by the stream |
| seg_mem_size | input | 16 | Bytes the segment occupies in memory |
| seg_exec | input | 1 | 1: executable segment |
| busy | output | 1 | A segment is in progress |
| in_valid | input | 1 | Source byte valid |
| in_data | input | 8 | Source byte |
| in_ready | output | 1 | Source byte taken when valid is also high |
| wr_en | output | 1 | Memory write request |
| wr_sel | output | 1 | 1: instruction memory, 0: data memory |
| wr_addr | output | 22 | Byte address of the write |
| wr_data | output | 8 | Byte to write |
| wr_stall | input | 1 | Memory cannot take the write this cycle |
| done | output | 1 | One-cycle completion pulse |
| seg_err | output | 1 | One-cycle pulse on a refused descriptor |

## Verification
Executable segments are fed with lengths that are a multiple of three and with a ragged tail, which separates correct group padding from padding that is emitted too early, too late or after a short final group. Data segments are run with fill, without fill and with no source bytes at all, which tells apart the copy-then-fill boundary from an off-by-one at either end. Periodic memory stalls combined with gaps in the source valid show whether a held write or a stalled handshake ever drops, repeats or reorders a byte. A refused descriptor, empty segments and a second start during a busy segment check that nothing is written when nothing should be.

// File: rtl/segld_pkg.sv
package segld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_COPY  = 3'd1,
        ST_PAD   = 3'd2,
        ST_FILL  = 3'd3,
        ST_FLUSH = 3'd4
    } seg_state_e;

    localparam logic SEL_IMEM = 1'b1;
    localparam logic SEL_DMEM = 1'b0;

endpackage

// File: rtl/segld_desc.sv
module segld_desc
    import segld_pkg::*;
#(
    parameter int PADDR_W   = 32,
    parameter int SIZE_W    = 16,
    parameter int WOFF_BITS = 20,
    localparam int ADDR_W   = WOFF_BITS + 2
) (
    input  logic [PADDR_W-1:0] paddr,
    input  logic [SIZE_W-1:0]  file_size,
    input  logic [SIZE_W-1:0]  mem_size,
    input  logic               exec,
    output logic [ADDR_W-1:0]  base_addr,
    output logic               reject,
    output seg_state_e         first_state
);

    // Word address to byte address: keep the low word bits, times four.
    assign base_addr = {paddr[WOFF_BITS-1:0], 2'b00};

    generate
        if (PADDR_W > WOFF_BITS) begin : g_hi_bits
            logic unused_hi;
            assign unused_hi = ^paddr[PADDR_W-1:WOFF_BITS];
        end
    endgenerate

    assign reject = (file_size > mem_size);

    always_comb begin
        if (exec) begin
            first_state = (file_size == '0) ? ST_FLUSH : ST_COPY;
        end else if (file_size != '0) begin
            first_state = ST_COPY;
        end else if (mem_size != '0) begin
            first_state = ST_FILL;
        end else begin
            first_state = ST_FLUSH;
        end
    end

endmodule

// File: rtl/segld_wport.sv
module segld_wport #(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic              issue_sel,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] issue_data,
    input  logic              wr_stall,
    output logic              slot_free,
    output logic              wr_en,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              en;
        logic              sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wp_t;

    wp_t w_d, w_q;

    always_comb begin
        slot_free = !w_q.en || !wr_stall;
        w_d       = w_q;
        if (issue) begin
            w_d.en   = 1'b1;
            w_d.sel  = issue_sel;
            w_d.addr = issue_addr;
            w_d.data = issue_data;
        end else if (slot_free) begin
            w_d.en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    assign wr_en   = w_q.en;
    assign wr_sel  = w_q.sel;
    assign wr_addr = w_q.addr;
    assign wr_data = w_q.data;

    // R6: a stalled write is held unchanged.
    a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.en && wr_stall) |=> (w_q.en && $stable(w_q.addr)
                                  && $stable(w_q.data) && $stable(w_q.sel)));

    // R6: the sequencer never issues into an occupied, stalled slot.
    a_r6_issue_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (!w_q.en || !wr_stall));

endmodule

// File: rtl/segld_seq.sv
module segld_seq
    import segld_pkg::*;
#(
    parameter int SIZE_W = 16,
    parameter int ADDR_W = 22,
    parameter int GROUP  = 3,
    localparam int GRP_W = (GROUP > 2) ? $clog2(GROUP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              seg_exec,
    input  logic [SIZE_W-1:0] file_size,
    input  logic [SIZE_W-1:0] mem_size,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              reject,
    input  seg_state_e        first_state,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic              slot_free,
    output logic              issue,
    output logic              issue_sel,
    output logic [ADDR_W-1:0] issue_addr,
    output logic [7:0]        issue_data,
    output logic              busy,
    output logic              done,
    output logic              seg_err
);

    typedef struct packed {
        seg_state_e        state;
        logic              exec;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] file;
        logic [SIZE_W-1:0] mem;
        logic [SIZE_W-1:0] src;
        logic [SIZE_W-1:0] tot;
        logic [GRP_W-1:0]  grp;
        logic              done;
        logic              err;
    } seq_t;

    seq_t s_d, s_q;

    logic [SIZE_W-1:0] src_inc;
    logic [SIZE_W-1:0] tot_inc;
    logic              last_src;
    logic              group_full;

    assign src_inc    = s_q.src + SIZE_W'(1);
    assign tot_inc    = s_q.tot + SIZE_W'(1);
    assign last_src   = (src_inc == s_q.file);
    assign group_full = (s_q.grp == GRP_W'(GROUP - 1));

    always_comb begin
        s_d        = s_q;
        s_d.done   = 1'b0;
        s_d.err    = 1'b0;
        issue      = 1'b0;
        issue_data = 8'h00;
        in_ready   = 1'b0;

        case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (reject) begin
                        s_d.err = 1'b1;
                    end else begin
                        s_d.state = first_state;
                        s_d.exec  = seg_exec;
                        s_d.addr  = base_addr;
                        s_d.file  = file_size;
                        s_d.mem   = mem_size;
                        s_d.src   = '0;
                        s_d.tot   = '0;
                        s_d.grp   = '0;
                    end
                end
            end

            ST_COPY: begin
                in_ready = slot_free;
                if (in_valid && slot_free) begin
                    issue      = 1'b1;
                    issue_data = in_data;
                    s_d.addr   = s_q.addr + ADDR_W'(1);
                    s_d.src    = src_inc;
                    s_d.tot    = tot_inc;
                    if (s_q.exec) begin
                        if (group_full) begin
                            s_d.grp   = '0;
                            s_d.state = ST_PAD;
                        end else begin
                            s_d.grp = s_q.grp + GRP_W'(1);
                            if (last_src) begin
                                s_d.state = ST_FLUSH;
                            end
                        end
                    end else if (last_src) begin
                        s_d.state = (tot_inc == s_q.mem) ? ST_FLUSH : ST_FILL;
                    end
                end
            end

            ST_PAD: begin
                if (slot_free) begin
                    issue     = 1'b1;
                    s_d.addr  = s_q.addr + ADDR_W'(1);
                    s_d.state = (s_q.src == s_q.file) ? ST_FLUSH : ST_COPY;
                end
            end

            ST_FILL: begin
                if (slot_free) begin
                    issue    = 1'b1;
                    s_d.addr = s_q.addr + ADDR_W'(1);
                    s_d.tot  = tot_inc;
                    if (tot_inc == s_q.mem) begin
                        s_d.state = ST_FLUSH;
                    end
                end
            end

            ST_FLUSH: begin
                if (slot_free) begin
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end
            end

            default: begin
                s_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign issue_sel  = s_q.exec ? SEL_IMEM : SEL_DMEM;
    assign issue_addr = s_q.addr;
    assign busy       = (s_q.state != ST_IDLE);
    assign done       = s_q.done;
    assign seg_err    = s_q.err;

    // R9: the latched descriptor does not change while a segment runs.
    a_r9_desc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(s_q.file) && $stable(s_q.mem)
                                   && $stable(s_q.exec)));

    // R5: padding happens only inside executable segments.
    a_r5_pad_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_PAD) |-> s_q.exec);

    // R6: bytes are offered to the stream only with room downstream.
    a_r6_ready_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> slot_free);

endmodule

// File: rtl/seg_image_packer.sv
module seg_image_packer
    import segld_pkg::*;
#(
    parameter int PADDR_W   = 32,
    parameter int SIZE_W    = 16,
    parameter int WOFF_BITS = 20,
    parameter int GROUP     = 3,
    localparam int ADDR_W   = WOFF_BITS + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_start,
    input  logic [PADDR_W-1:0] seg_paddr,
    input  logic [SIZE_W-1:0]  seg_file_size,
    input  logic [SIZE_W-1:0]  seg_mem_size,
    input  logic               seg_exec,
    output logic               busy,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               wr_en,
    output logic               wr_sel,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [7:0]         wr_data,
    input  logic               wr_stall,
    output logic               done,
    output logic               seg_err
);

    logic [ADDR_W-1:0] base_addr;
    logic              reject;
    seg_state_e        first_state;
    logic              slot_free;
    logic              issue;
    logic              issue_sel;
    logic [ADDR_W-1:0] issue_addr;
    logic [7:0]        issue_data;

    segld_desc #(
        .PADDR_W  (PADDR_W),
        .SIZE_W   (SIZE_W),
        .WOFF_BITS(WOFF_BITS)
    ) u_desc (
        .paddr      (seg_paddr),
        .file_size  (seg_file_size),
        .mem_size   (seg_mem_size),
        .exec       (seg_exec),
        .base_addr  (base_addr),
        .reject     (reject),
        .first_state(first_state)
    );

    segld_seq #(
        .SIZE_W(SIZE_W),
        .ADDR_W(ADDR_W),
        .GROUP (GROUP)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (seg_start),
        .seg_exec   (seg_exec),
        .file_size  (seg_file_size),
        .mem_size   (seg_mem_size),
        .base_addr  (base_addr),
        .reject     (reject),
        .first_state(first_state),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .slot_free  (slot_free),
        .issue      (issue),
        .issue_sel  (issue_sel),
        .issue_addr (issue_addr),
        .issue_data (issue_data),
        .busy       (busy),
        .done       (done),
        .seg_err    (seg_err)
    );

    segld_wport #(
        .ADDR_W(ADDR_W),
        .DATA_W(8)
    ) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue     (issue),
        .issue_sel (issue_sel),
        .issue_addr(issue_addr),
        .issue_data(issue_data),
        .wr_stall  (wr_stall),
        .slot_free (slot_free),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // R8: a refused descriptor leaves the block idle with nothing to write.
    a_r8_reject_silent: assert property (@(posedge clk) disable iff (!rst_n)
        seg_err |-> (!busy && !wr_en));

    // R7: completion is only signalled once the write stage is empty.
    a_r7_done_drained: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_en && !busy));

endmodule

// File: tb/test_seg_image_packer.sv
module test_seg_image_packer;

    localparam int ADDR_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              seg_start = 1'b0;
    logic [31:0]       seg_paddr = '0;
    logic [15:0]       seg_file_size = '0;
    logic [15:0]       seg_mem_size = '0;
    logic              seg_exec = 1'b0;
    logic              busy;
    logic              in_valid = 1'b0;
    logic [7:0]        in_data = 8'h00;
    logic              in_ready;
    logic              wr_en;
    logic              wr_sel;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              wr_stall = 1'b0;
    logic              done;
    logic              seg_err;

    always #2 clk = ~clk;

    seg_image_packer i_seg_image_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg_start    (seg_start),
        .seg_paddr    (seg_paddr),
        .seg_file_size(seg_file_size),
        .seg_mem_size (seg_mem_size),
        .seg_exec     (seg_exec),
        .busy         (busy),
        .in_valid     (in_valid),
        .in_data      (in_data),
        .in_ready     (in_ready),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_stall     (wr_stall),
        .done         (done),
        .seg_err      (seg_err)
    );

    int checks = 0;
    int errors = 0;

    // Stream source and observation logs (append-only, written by monitor).
    logic [7:0]        src_q[$];
    int                src_idx = 0;
    int                stall_per = 0;
    int                gap_per = 0;
    int                cyc = 0;
    logic              log_sel[$];
    logic [ADDR_W-1:0] log_addr[$];
    logic [7:0]        log_data[$];
    int                done_cnt = 0;
    int                err_cnt = 0;
    int                hold_bad = 0;
    int                ready_seen = 0;
    logic              prev_hold = 1'b0;
    logic [ADDR_W-1:0] prev_addr = '0;
    logic [7:0]        prev_data = '0;
    logic              prev_sel = 1'b0;

    logic              exp_sel[$];
    logic [ADDR_W-1:0] exp_addr[$];
    logic [7:0]        exp_data[$];

    always @(negedge clk) begin
        wr_stall = (stall_per != 0) && (cyc % stall_per == 0);
        in_valid = (src_idx < src_q.size()) && !((gap_per != 0) && (cyc % gap_per == 1));
        in_data  = in_valid ? src_q[src_idx] : 8'h00;
        #1;
        if (prev_hold && (!wr_en || wr_addr != prev_addr || wr_data != prev_data || wr_sel != prev_sel))
            hold_bad++;
        prev_hold = wr_en && wr_stall;
        prev_addr = wr_addr;
        prev_data = wr_data;
        prev_sel  = wr_sel;
        if (in_ready) ready_seen++;
        if (in_valid && in_ready) src_idx++;
        if (wr_en && !wr_stall) begin
            log_sel.push_back(wr_sel);
            log_addr.push_back(wr_addr);
            log_data.push_back(wr_data);
        end
        if (done) done_cnt++;
        if (seg_err) err_cnt++;
        cyc++;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic build_expected(input logic [31:0] paddr, input int fsz, input int msz,
                                  input bit ex, input int first);
        logic [ADDR_W-1:0] a;
        exp_sel.delete();
        exp_addr.delete();
        exp_data.delete();
        a = {paddr[19:0], 2'b00};
        for (int i = 0; i < fsz; i++) begin
            exp_sel.push_back(ex);
            exp_addr.push_back(a);
            exp_data.push_back(src_q[first + i]);
            a = a + 1'b1;
            if (ex && (i % 3 == 2)) begin
                exp_sel.push_back(ex);
                exp_addr.push_back(a);
                exp_data.push_back(8'h00);
                a = a + 1'b1;
            end
        end
        if (!ex) begin
            for (int i = fsz; i < msz; i++) begin
                exp_sel.push_back(1'b0);
                exp_addr.push_back(a);
                exp_data.push_back(8'h00);
                a = a + 1'b1;
            end
        end
    endtask

    task automatic run_seg(input string tag, input logic [31:0] paddr, input int fsz,
                           input int msz, input bit ex, input int sp, input int gp,
                           input bit restart, input bit expect_err, input bit feed,
                           input int seed);
        int l0, s0, d0, e0, h0, r0, first, n, bad_at;
        l0 = log_data.size();
        s0 = src_idx;
        d0 = done_cnt;
        e0 = err_cnt;
        h0 = hold_bad;
        r0 = ready_seen;
        first = src_q.size();
        if (feed)
            for (int i = 0; i < fsz; i++) src_q.push_back(8'((i * 29 + seed * 7 + 3) % 256));
        if (expect_err) begin
            exp_sel.delete();
            exp_addr.delete();
            exp_data.delete();
        end else begin
            build_expected(paddr, fsz, msz, ex, first);
        end
        stall_per = sp;
        gap_per   = gp;
        @(negedge clk);
        seg_start     = 1'b1;
        seg_paddr     = paddr;
        seg_file_size = 16'(fsz);
        seg_mem_size  = 16'(msz);
        seg_exec      = ex;
        @(negedge clk);
        seg_start = 1'b0;
        if (restart) begin
            repeat (2) @(negedge clk);
            seg_start     = 1'b1;
            seg_paddr     = paddr ^ 32'h0000_0F00;
            seg_exec      = !ex;
            seg_mem_size  = 16'(msz + 40);
            @(negedge clk);
            seg_start = 1'b0;
        end
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (done_cnt > d0 || err_cnt > e0) break;
        end
        repeat (8) @(negedge clk);
        #2;
        stall_per = 0;
        gap_per   = 0;

        n = log_data.size() - l0;
        check(n == exp_data.size(), tag, "write count", n, exp_data.size());
        bad_at = -1;
        for (int i = 0; i < n && i < exp_data.size(); i++) begin
            if (bad_at < 0 && (log_sel[l0+i] != exp_sel[i] || log_addr[l0+i] != exp_addr[i]
                               || log_data[l0+i] != exp_data[i]))
                bad_at = i;
        end
        if (bad_at >= 0)
            check(1'b0, tag, $sformatf("write %0d sel/addr/data %0d/%0h/%0h vs %0d/%0h/%0h",
                  bad_at, log_sel[l0+bad_at], log_addr[l0+bad_at], log_data[l0+bad_at],
                  exp_sel[bad_at], exp_addr[bad_at], exp_data[bad_at]), bad_at, -1);
        else
            check(1'b1, tag, "write content", 0, 0);
        check((done_cnt - d0) == (expect_err ? 0 : 1), "R7", "done pulses",
              done_cnt - d0, expect_err ? 0 : 1);
        check((err_cnt - e0) == (expect_err ? 1 : 0), "R8", "error pulses",
              err_cnt - e0, expect_err ? 1 : 0);
        check((src_idx - s0) == (expect_err ? 0 : fsz), "R6", "bytes taken",
              src_idx - s0, expect_err ? 0 : fsz);
        check(hold_bad == h0, "R6", "stalled write changed", hold_bad - h0, 0);
        if (expect_err)
            check(ready_seen == r0, "R8", "ready cycles", ready_seen - r0, 0);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R9", "busy after reset", busy, 0);
        check(in_ready == 1'b0, "R9", "in_ready after reset", in_ready, 0);
        check(wr_en == 1'b0, "R9", "wr_en after reset", wr_en, 0);
        check(done == 1'b0, "R9", "done after reset", done, 0);
    endtask

    task automatic t_exec_whole();   // R1 R2 R3 R5
        run_seg("R1 R2 R3 R5 exec9", 32'h0000_0040, 9, 9, 1'b1, 0, 0, 1'b0, 1'b0, 1'b1, 1);
    endtask

    task automatic t_exec_ragged();  // R2 R5 R6, memory size larger than needed
        run_seg("R2 R5 R6 exec7", 32'hF000_0300, 7, 20, 1'b1, 3, 4, 1'b0, 1'b0, 1'b1, 2);
    endtask

    task automatic t_data_fill();    // R1 R3 R4, upper address bits dropped
        run_seg("R1 R3 R4 data5of12", 32'hABC1_2345, 5, 12, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 3);
    endtask

    task automatic t_data_exact();   // R4 R6
        run_seg("R4 R6 data6of6", 32'h0000_0800, 6, 6, 1'b0, 2, 3, 1'b0, 1'b0, 1'b1, 4);
    endtask

    task automatic t_reject();       // R8
        run_seg("R8 reject", 32'h0000_0010, 10, 4, 1'b1, 0, 0, 1'b0, 1'b1, 1'b0, 5);
    endtask

    task automatic t_empty();        // R10 R4
        run_seg("R10 exec empty", 32'h0000_0020, 0, 8, 1'b1, 0, 0, 1'b0, 1'b0, 1'b1, 6);
        run_seg("R10 data empty", 32'h0000_0030, 0, 0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1, 7);
        run_seg("R4 R10 data fill only", 32'h0000_0034, 0, 3, 1'b0, 2, 0, 1'b0, 1'b0, 1'b1, 8);
    endtask

    task automatic t_restart();      // R9
        run_seg("R9 start while busy", 32'h0001_0000, 12, 16, 1'b1, 2, 0, 1'b1, 1'b0, 1'b1, 9);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            errors++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", wd, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_exec_whole();
        t_exec_ragged();
        t_data_fill();
        t_data_exact();
        t_reject();
        t_empty();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule